// File: doc/BRIEF.md
# SDRAM clock-enable power state controller

This block follows the clock-enable line of an SDRAM device and keeps track of which power state the device is in. The states are normal operation, precharge power-down, active power-down, self refresh, and a timed window that follows self-refresh exit. The controller's command path gives it the current and previous clock-enable samples, the decoded command of the cycle, a flag that all banks are idle, and a flag that an access or auto refresh is still in flight. The block then decides whether the requested transition is legal.

The block has three outputs. It reports the power state. It raises a read-permitted flag only when a READ could be issued. It pulses a violation strobe for one cycle when the command stream breaks a clock-enable rule. The bank state machines and refresh counting stay outside the block and are seen only through the two flags.

Top module: `pwr_cke_ctrl`

## Requirements
- R1: After reset the state is normal (state_o = 0), rd_ok_o is 1 and viol_o is 0. State codes are: 0 normal, 1 precharge power-down, 2 active power-down, 3 self refresh, 4 self-refresh exit window. rd_ok_o is 1 exactly when the state is normal.
- R2: In normal state, clock enable falling (previous 1, current 0) with NOP (cmd 0) or DESELECT (cmd 1) and no access in flight moves to precharge power-down when all banks are idle. If a bank is open it moves to active power-down instead. The new state shows after the next clock edge.
- R3: In normal state, clock enable falling with AUTO REFRESH (cmd 6), all banks idle and no access in flight enters self refresh. If a bank is open, the block flags a violation and stays normal.
- R4: Clock enable rising (previous 0, current 1) in either power-down state returns to normal on the next cycle. While clock enable stays low, commands cause no state change and no violation.
- R5: In normal state, clock enable falling while busy_i is high is a violation and the state stays normal. Falling with any command other than NOP, DESELECT or AUTO REFRESH is also a violation that leaves the state normal. Those other commands are ACTIVE 2, READ 3, WRITE 4, PRECHARGE 5 and MODE 7.
- R6: On the cycle clock enable rises out of a power-down or self-refresh state, a command other than NOP or DESELECT pulses viol_o. The state transition still takes place.
- R7: Clock enable rising in self refresh enters the exit window. The window lasts EXIT_CYC-1 cycles and rd_ok_o is 0 throughout it. A READ presented EXIT_CYC-1 cycles after the exit edge is a violation. A READ presented EXIT_CYC cycles after it is accepted in normal state.
- R8: Inside the exit window, commands other than READ raise no violation. READ, or clock enable falling, pulses viol_o and the window continues.
- R9: viol_o is registered. It is high for exactly the one cycle after the sampled offending input and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cke_i | input | 1 | Clock-enable sample of this cycle |
| cke_prev_i | input | 1 | Clock-enable sample of the previous cycle |
| cmd_i | input | 3 | Decoded command (0 NOP, 1 DESELECT, 2 ACTIVE, 3 READ, 4 WRITE, 5 PRECHARGE, 6 AUTO REFRESH, 7 MODE) |
| all_idle_i | input | 1 | All banks precharged |
| busy_i | input | 1 | Read, write or auto refresh still in progress |
| state_o | output | 3 | Power state code |
| rd_ok_o | output | 1 | READ may be issued |
| viol_o | output | 1 | One-cycle clock-enable rule violation strobe |

## Verification
The falling edge of clock enable is tried with NOP under idle and under open banks, which separates the two power-down states. It is also tried with AUTO REFRESH under idle and under open banks, which separates self-refresh entry from an illegal refresh entry. Falls during a busy access and falls carrying an access command check that the state holds and the strobe fires. Exits are driven with quiet and non-quiet commands to show that the transition and the strobe act independently. The exit window is swept one cycle at a time with ACTIVE, PRECHARGE and a stray clock-enable drop. READ is placed at the last blocked cycle and at the first permitted cycle, which pins down the window length exactly.

// File: rtl/pwr_cke_pkg.sv
package pwr_cke_pkg;
  typedef enum logic [2:0] {
    CMD_NOP   = 3'd0,
    CMD_DESEL = 3'd1,
    CMD_ACT   = 3'd2,
    CMD_RD    = 3'd3,
    CMD_WR    = 3'd4,
    CMD_PRE   = 3'd5,
    CMD_AREF  = 3'd6,
    CMD_MODE  = 3'd7
  } cmd_e;

  typedef enum logic [2:0] {
    PS_NORMAL = 3'd0,
    PS_PPD    = 3'd1,
    PS_APD    = 3'd2,
    PS_SREF   = 3'd3,
    PS_SRX    = 3'd4
  } pstate_e;
endpackage

// File: rtl/cke_evt_dec.sv
module cke_evt_dec
  import pwr_cke_pkg::*;
(
  input  logic       cke_i,
  input  logic       cke_prev_i,
  input  logic [2:0] cmd_i,
  output logic       rise_o,
  output logic       fall_o,
  output logic       quiet_o,
  output logic       aref_o,
  output logic       rd_o
);
  cmd_e cmd;
  assign cmd     = cmd_e'(cmd_i);
  assign rise_o  = ~cke_prev_i & cke_i;
  assign fall_o  = cke_prev_i & ~cke_i;
  assign quiet_o = (cmd == CMD_NOP) || (cmd == CMD_DESEL);
  assign aref_o  = (cmd == CMD_AREF);
  assign rd_o    = (cmd == CMD_RD);
endmodule

// File: rtl/srx_timer.sv
module srx_timer #(
  parameter int EXIT_CYC = 200
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic done_o
);
  localparam int CW = (EXIT_CYC > 2) ? $clog2(EXIT_CYC) : 1;
  localparam logic [CW-1:0] LOAD_VAL = CW'(EXIT_CYC - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= LOAD_VAL;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  // last blocked cycle of the window
  assign done_o = (cnt_q == CW'(1));

  generate
    if (EXIT_CYC > 2) begin : g_chk
      // R7
      no_early_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        load_i |=> !done_o);
    end
  endgenerate
endmodule

// File: rtl/pwr_cke_ctrl.sv
module pwr_cke_ctrl
  import pwr_cke_pkg::*;
#(
  parameter int EXIT_CYC = 200
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cke_i,
  input  logic       cke_prev_i,
  input  logic [2:0] cmd_i,
  input  logic       all_idle_i,
  input  logic       busy_i,
  output logic [2:0] state_o,
  output logic       rd_ok_o,
  output logic       viol_o
);
  pstate_e st_q, st_d;
  logic rise, fall, quiet, aref, rd;
  logic vio_d, viol_q, tmr_load, tmr_done;

  cke_evt_dec u_dec (
    .cke_i     (cke_i),
    .cke_prev_i(cke_prev_i),
    .cmd_i     (cmd_i),
    .rise_o    (rise),
    .fall_o    (fall),
    .quiet_o   (quiet),
    .aref_o    (aref),
    .rd_o      (rd)
  );

  srx_timer #(.EXIT_CYC(EXIT_CYC)) u_tmr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(tmr_load),
    .done_o(tmr_done)
  );

  always_comb begin
    st_d     = st_q;
    vio_d    = 1'b0;
    tmr_load = 1'b0;
    unique case (st_q)
      PS_NORMAL: if (fall) begin
        if (busy_i)                  vio_d = 1'b1;
        else if (aref && all_idle_i) st_d  = PS_SREF;
        else if (quiet)              st_d  = all_idle_i ? PS_PPD : PS_APD;
        else                         vio_d = 1'b1;
      end
      PS_PPD, PS_APD: if (rise) begin
        st_d  = PS_NORMAL;
        vio_d = ~quiet;
      end
      PS_SREF: if (rise) begin
        st_d     = PS_SRX;
        tmr_load = 1'b1;
        vio_d    = ~quiet;
      end
      PS_SRX: begin
        vio_d = rd | fall;
        if (tmr_done) st_d = PS_NORMAL;
      end
      default: st_d = PS_NORMAL;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= PS_NORMAL;
      viol_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      viol_q <= vio_d;
    end
  end

  assign state_o = st_q;
  assign rd_ok_o = (st_q == PS_NORMAL);
  assign viol_o  = viol_q;

  // R5
  busy_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == PS_NORMAL && fall && busy_i) |=> (viol_o && state_o == PS_NORMAL));
  // R3
  sref_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == PS_NORMAL && fall && aref && all_idle_i && !busy_i) |=> state_o == PS_SREF);
  // R4
  pd_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((st_q == PS_PPD || st_q == PS_APD) && rise) |=> state_o == PS_NORMAL);
  // R7
  srx_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == PS_SREF && rise) |=> (state_o == PS_SRX && !rd_ok_o));
  // R8
  srx_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == PS_SRX && rd) |=> viol_o);
  // R6
  noisy_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((st_q == PS_PPD || st_q == PS_APD || st_q == PS_SREF) && rise && !quiet) |=> viol_o);
endmodule

// File: tb/pwr_cke_ctrl_tb.sv
module pwr_cke_ctrl_tb;
  localparam int EXIT = 200;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic cke_i = 1'b1, cke_prev_i = 1'b1, all_idle_i = 1'b1, busy_i = 1'b0;
  logic [2:0] cmd_i = 3'd0;
  logic [2:0] state_o;
  logic rd_ok_o, viol_o;

  int checks = 0, fails = 0;
  string req = "R1";
  logic cke_q = 1'b1;
  bit done = 0;

  always #10 clk_i = ~clk_i;

  pwr_cke_ctrl #(.EXIT_CYC(EXIT)) u_dut (
    .clk_i, .rst_ni, .cke_i, .cke_prev_i, .cmd_i,
    .all_idle_i, .busy_i, .state_o, .rd_ok_o, .viol_o
  );

  // behavioural reference
  int m_state, m_n, m_exit;
  bit m_viol;
  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_state = 0; m_viol = 0; m_n = 0; m_exit = 0;
    end else begin
      bit rise, fall, quiet, v;
      int ns;
      m_n++;
      rise  = !cke_prev_i && cke_i;
      fall  = cke_prev_i && !cke_i;
      quiet = (cmd_i == 3'd0) || (cmd_i == 3'd1);
      v = 0; ns = m_state;
      if (m_state == 0) begin
        if (fall) begin
          if (busy_i) v = 1;
          else if (cmd_i == 3'd6) begin if (all_idle_i) ns = 3; else v = 1; end
          else if (quiet) ns = all_idle_i ? 1 : 2;
          else v = 1;
        end
      end else if (m_state == 1 || m_state == 2) begin
        if (rise) begin ns = 0; v = !quiet; end
      end else if (m_state == 3) begin
        if (rise) begin ns = 4; m_exit = m_n; v = !quiet; end
      end else begin
        if (cmd_i == 3'd3 || fall) v = 1;
        if (m_n - m_exit >= EXIT - 1) ns = 0;
      end
      m_state = ns; m_viol = v;
    end
  end

  task automatic compare();
    checks++;
    if (state_o !== 3'(m_state) || rd_ok_o !== (m_state == 0) || viol_o !== m_viol) begin
      fails++;
      $display("FAIL %s: state=%0d rd_ok=%0b viol=%0b expected state=%0d rd_ok=%0b viol=%0b",
               req, state_o, rd_ok_o, viol_o, m_state, (m_state == 0), m_viol);
    end
  endtask

  task automatic step(input logic c, input logic [2:0] cmd, input logic idle, input logic bsy);
    cke_prev_i = cke_q; cke_i = c; cmd_i = cmd; all_idle_i = idle; busy_i = bsy; cke_q = c;
    @(posedge clk_i); @(negedge clk_i);
    compare();
  endtask

  initial begin
    #30000000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    req = "R1"; compare();
    rst_ni = 1'b1;
    step(1, 3'd2, 0, 0); step(1, 3'd3, 0, 1); step(1, 3'd4, 0, 1); step(1, 3'd0, 0, 0);
    // R2 precharge power-down, R4 exit
    req = "R2"; step(0, 3'd0, 1, 0);
    req = "R4"; step(0, 3'd2, 1, 0); step(0, 3'd3, 1, 0); step(1, 3'd1, 1, 0); step(1, 3'd0, 1, 0);
    // R2 active power-down, R6 noisy exit
    req = "R2"; step(0, 3'd1, 0, 0); step(0, 3'd0, 0, 0);
    req = "R6"; step(1, 3'd2, 0, 0); step(1, 3'd0, 0, 0);
    // R5 fall during access / with access command
    req = "R5"; step(0, 3'd0, 1, 1); step(1, 3'd0, 1, 0);
    step(0, 3'd4, 1, 0); step(1, 3'd0, 1, 0);
    step(0, 3'd6, 1, 1); step(1, 3'd0, 1, 0);
    // R3 refresh entry with open bank, then with idle banks
    req = "R3"; step(0, 3'd6, 0, 0); step(1, 3'd0, 0, 0);
    step(0, 3'd6, 1, 0); step(0, 3'd5, 1, 0); step(0, 3'd0, 1, 0);
    // R7 exit window
    req = "R7"; step(1, 3'd1, 1, 0);
    for (int k = 1; k <= EXIT - 2; k++) begin
      req = "R8";
      case (k)
        10: step(1, 3'd2, 0, 0);
        11: step(1, 3'd5, 1, 0);
        12: step(1, 3'd7, 1, 0);
        20: step(1, 3'd3, 1, 0);
        30: step(0, 3'd0, 1, 0);
        default: step(1, 3'd0, 1, 0);
      endcase
    end
    req = "R7"; step(1, 3'd3, 1, 0); step(1, 3'd3, 1, 0); step(1, 3'd0, 1, 0);
    // R6 noisy self-refresh exit, R9 single pulse
    req = "R6"; step(0, 3'd6, 1, 0); step(0, 3'd0, 1, 0); step(1, 3'd3, 1, 0);
    req = "R9"; step(1, 3'd0, 1, 0); step(1, 3'd0, 1, 0);
    for (int k = 0; k < EXIT; k++) step(1, 3'd0, 1, 0);
    req = "R9"; step(1, 3'd3, 1, 0); step(1, 3'd0, 1, 0);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule